// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a column command into the series of column addresses that a synchronous DRAM burst walks through. A mode word, loaded by a mode-register-set strobe, selects the burst length, the ordering of the beats, the read latency code and a single-beat-write option. Each start strobe carries a start column and a read/write flag. From the cycle after the strobe, the block presents one column per clock with a valid flag. It raises a last-beat flag on the final column of the burst.

Bursts of 1, 2, 4 and 8 beats stay inside the aligned block of that size. In sequential order the column counts up and wraps at the block edge. In interleaved order the beat index is XORed into the low bits of the start column. A full-page burst walks all 256 columns, wraps around, and runs until a terminate strobe or a new start. A new start or a terminate ends the running burst at once. A mode word with a reserved code is rejected and raises an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o and last_o are 0, mode_err_o is 0, and the mode is: length 1, sequential, latency code 3 (cas_lat_o = 3), single-beat write off.
- R2: On mode_load_i with a legal word, the fields are taken from mode_word_i: bits [2:0] length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 order (0 sequential, 1 interleaved), bits [6:4] latency code (001, 010, 011), bit 7 single-beat write. From the next cycle cas_lat_o shows bits [5:4] and mode_err_o is 0.
- R3: A word is reserved if its length code is 100, 101 or 110, or is 111 with bit 3 set, or if its latency code is not 001 to 011. Such a word leaves the whole mode unchanged and sets mode_err_o from the next cycle. mode_err_o stays set until a legal word is loaded.
- R4: In the cycle after start_i, valid_o is 1 and col_o equals start_col_i. Without a start, valid_o is never raised.
- R5: In sequential order, beat k gives the start column's low bits plus k, taken modulo the length, with the upper bits kept (length 8 from 0x45: 45,46,47,40,41,42,43,44).
- R6: In interleaved order, beat k gives the start column's low bits XOR k, with the upper bits kept (length 8 from 0x45: 45,44,47,46,41,40,43,42).
- R7: A burst of length N keeps valid_o high for exactly N cycles. last_o is high only on the N-th beat, and valid_o falls in the following cycle unless a new start arrives.
- R8: A full-page burst steps through all 256 columns, wraps from 0xFF to 0x00, never raises last_o and continues until ended.
- R9: With single-beat write set, a start with is_write_i = 1 gives a one-beat burst, whatever the length code. A start with is_write_i = 0 uses the programmed length.
- R10: term_i without start_i drops valid_o in the next cycle.
- R11: start_i during a burst replaces it at once with the new burst. This holds with starts on consecutive cycles. When start_i and term_i come together, the start wins.
- R12: Length and order are captured at start_i. A mode load during a burst, or in the same cycle as its start, affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Mode-register-set strobe |
| mode_word_i | input | 8 | Mode word |
| start_i | input | 1 | Column command strobe |
| start_col_i | input | COL_W | Start column of the burst |
| is_write_i | input | 1 | 1 = write command, 0 = read |
| term_i | input | 1 | Burst terminate strobe |
| col_o | output | COL_W | Current burst column |
| valid_o | output | 1 | col_o carries a burst beat |
| last_o | output | 1 | Final beat of a bounded burst |
| cas_lat_o | output | 2 | Programmed read latency |
| mode_err_o | output | 1 | Last mode word was rejected |

## Verification
The bench starts bursts that wrap inside their aligned block, so a design that carried into the upper column bits would leave the block. It checks interleaved order against sequential order from the same start. A design that swapped them, or added where it should XOR, gives a different series. A full-page burst is run past the 0xFF to 0x00 wrap. This catches a counter that stops at 255 and a last flag that fires during full page. The bench also sends reserved words of every kind, starts on consecutive cycles, a start together with a terminate, and mode loads inside a burst. A design that partly took a bad word, gave a terminate priority, or read the live mode during a burst would show a wrong column, length or error flag.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int BL_CODE_W = 3;
  localparam int CL_CODE_W = 3;
  localparam int MODE_W    = 8;
  localparam logic [BL_CODE_W-1:0] BL_FULL_PAGE = 3'b111;
  localparam logic [BL_CODE_W-1:0] BL_MAX_POW   = 3'b011;

  // packed order matches the mode word: [7] wr_single, [6:4] cl, [3] ilv, [2:0] bl
  typedef struct packed {
    logic                 wr_single;
    logic [CL_CODE_W-1:0] cl_code;
    logic                 ilv;
    logic [BL_CODE_W-1:0] bl_code;
  } mode_t;

  function automatic logic mode_legal(input mode_t m);
    logic bl_ok;
    logic cl_ok;
    bl_ok = (m.bl_code <= BL_MAX_POW) || ((m.bl_code == BL_FULL_PAGE) && !m.ilv);
    cl_ok = (m.cl_code != 3'd0) && (m.cl_code <= 3'd3);
    return bl_ok && cl_ok;
  endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter mode_t RST_MODE = '{wr_single: 1'b0, cl_code: 3'd3, ilv: 1'b0, bl_code: 3'd0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output mode_t             mode_o,
  output logic              err_o
);

  mode_t mode_q;
  mode_t word_m;
  logic  err_q;
  logic  legal;

  assign word_m = mode_t'(word_i);
  assign legal  = mode_legal(word_m);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RST_MODE;
      err_q  <= 1'b0;
    end else if (load_i) begin
      if (legal) begin
        mode_q <= word_m;
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  input  mode_t            mode_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] base_o,
  output logic             ilv_o
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q;
  logic             full_q;
  logic             ilv_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] base_q;

  logic             single_wr;
  logic             new_full;
  logic [COL_W-1:0] new_mask;
  logic             at_end;

  assign single_wr = is_write_i && mode_i.wr_single;
  assign new_full  = !single_wr && (mode_i.bl_code == BL_FULL_PAGE);

  always_comb begin
    if (single_wr)     new_mask = '0;
    else if (new_full) new_mask = '1;
    else               new_mask = (ONE << mode_i.bl_code[1:0]) - ONE;
  end

  assign at_end = active_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      beat_q   <= '0;
      mask_q   <= '0;
      base_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= new_full;
      ilv_q    <= mode_i.ilv && !single_wr;
      beat_q   <= '0;
      mask_q   <= new_mask;
      base_q   <= start_col_i;
    end else if (term_i || at_end) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      beat_q   <= beat_q + ONE;
    end
  end

  assign active_o = active_q;
  assign last_o   = at_end;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign base_o   = base_q;
  assign ilv_o    = ilv_q;

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  // carries out of the masked low field never reach it, so a plain add is exact
  assign seq_col = base_i + beat_i;
  assign ilv_col = base_i ^ beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = !mask_i[b] ? base_i[b] : (ilv_i ? ilv_col[b] : seq_col[b]);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              is_write_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [1:0]        cas_lat_o,
  output logic              mode_err_o
);

  mode_t            mode;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] base;
  logic             ilv;

  burst_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .word_i (mode_word_i),
    .mode_o (mode),
    .err_o  (mode_err_o)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .is_write_i  (is_write_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .mode_i      (mode),
    .active_o    (valid_o),
    .last_o      (last_o),
    .beat_o      (beat),
    .mask_o      (mask),
    .base_o      (base),
    .ilv_o       (ilv)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (col_o)
  );

  assign cas_lat_o = mode.cl_code[1:0];

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_load_i,
  input logic [7:0]       mode_word_i,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             is_write_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic [1:0]       cas_lat_o,
  input logic             mode_err_o
);

  logic word_ok;
  assign word_ok = ((mode_word_i[2:0] <= 3'd3) || (mode_word_i[2:0] == 3'd7 && !mode_word_i[3]))
                && (mode_word_i[6:4] >= 3'd1) && (mode_word_i[6:4] <= 3'd3);

  AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R7
  AST_END_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o); // R7
  AST_TERM_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> !valid_o); // R10
  AST_START_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> !valid_o); // R4
  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_load_i && !word_ok) |=> (mode_err_o && $stable(cas_lat_o))); // R3
  AST_ACCEPT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_load_i && word_ok) |=> (!mode_err_o && cas_lat_o == $past(mode_word_i[5:4]))); // R2

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_load_i = 1'b0;
  logic [7:0] mode_word_i = '0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic       is_write_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, mode_err_o;
  logic [1:0] cas_lat_o;

  always #4 clk = ~clk;

  burst_col_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_load_i(mode_load_i), .mode_word_i(mode_word_i),
    .start_i(start_i), .start_col_i(start_col_i), .is_write_i(is_write_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .cas_lat_o(cas_lat_o),
    .mode_err_o(mode_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  // reference state, built from the requirements
  int m_bl = 0, m_ilv = 0, m_cl = 3, m_ws = 0, m_err = 0;
  int b_act = 0, b_s = 0, b_k = 0, b_len = 1, b_ilv = 0;

  int    q_v[$], q_c[$], q_l[$], q_e[$], q_cl[$];
  string q_tag[$];

  function automatic int word_legal(input logic [7:0] w);
    int bl_ok, cl_ok;
    bl_ok = (w[2:0] <= 3) || (w[2:0] == 7 && !w[3]);
    cl_ok = (w[6:4] >= 1) && (w[6:4] <= 3);
    return bl_ok && cl_ok;
  endfunction

  function automatic int exp_col();
    int msk;
    msk = (b_len == 0) ? 255 : b_len - 1;
    if (b_ilv != 0) return (b_s & ~msk & 255) | ((b_s ^ b_k) & msk);
    return (b_s & ~msk & 255) | ((b_s + b_k) & msk);
  endfunction

  task automatic cyc(input logic ld, input logic [7:0] w, input logic st,
                     input logic [7:0] c, input logic wr, input logic tm);
    mode_load_i = ld; mode_word_i = w; start_i = st;
    start_col_i = c; is_write_i = wr; term_i = tm;
    @(posedge clk);
    if (st) begin
      b_act = 1; b_k = 0; b_s = c; b_ilv = m_ilv;
      if (wr && m_ws != 0) begin b_len = 1; b_ilv = 0; end
      else if (m_bl == 7) b_len = 0;
      else b_len = 1 << m_bl;
    end else if (tm) begin
      b_act = 0;
    end else if (b_act != 0) begin
      if (b_len != 0 && b_k == b_len - 1) b_act = 0;
      else b_k = (b_k + 1) & 255;
    end
    if (ld) begin
      if (word_legal(w) != 0) begin
        m_bl = w[2:0]; m_ilv = w[3]; m_cl = w[6:4]; m_ws = w[7]; m_err = 0;
      end else m_err = 1;
    end
    q_v.push_back(b_act);
    q_c.push_back(exp_col());
    q_l.push_back((b_act != 0 && b_len != 0 && b_k == b_len - 1) ? 1 : 0);
    q_e.push_back(m_err);
    q_cl.push_back(m_cl & 3);
    q_tag.push_back(tag);
    #1;
    mode_load_i = 0; start_i = 0; term_i = 0; is_write_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 8'h00, 0, 0);
  endtask

  task automatic load(input logic [7:0] w);
    cyc(1, w, 0, 8'h00, 0, 0);
  endtask

  task automatic burst(input logic [7:0] c, input logic wr, input int n);
    cyc(0, 8'h00, 1, c, wr, 0);
    idle(n);
  endtask

  // monitor: one expected item per clock after each driven edge
  always @(negedge clk) begin
    if (q_v.size() > 0) begin
      int v, c, l, e, cl;
      string t;
      v = q_v.pop_front(); c = q_c.pop_front(); l = q_l.pop_front();
      e = q_e.pop_front(); cl = q_cl.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (int'(valid_o) != v || (v != 0 && int'(col_o) != c) || int'(last_o) != l ||
          int'(mode_err_o) != e || int'(cas_lat_o) != cl) begin
        n_fail++;
        $display("FAIL %s: valid/col/last/err/cl = %0d/%02h/%0d/%0d/%0d expected %0d/%02h/%0d/%0d/%0d",
                 t, valid_o, col_o, last_o, mode_err_o, cas_lat_o, v, c[7:0], l, e, cl);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    n_chk++;
    if (valid_o || last_o || mode_err_o || cas_lat_o != 2'd3) begin
      n_fail++;
      $display("FAIL R1: valid/last/err/cl = %0d/%0d/%0d/%0d expected 0/0/0/3",
               valid_o, last_o, mode_err_o, cas_lat_o);
    end
    @(posedge clk); #1;
    tag = "R1"; burst(8'h37, 0, 2);        // reset length is one beat
    tag = "R4"; idle(2);                    // no start, no valid

    tag = "R2"; load(8'h32);               // len 4 seq, cl 3
    tag = "R5"; burst(8'h1D, 0, 5);
    tag = "R2"; load(8'h33);               // len 8 seq
    tag = "R5"; burst(8'h45, 0, 9);
    tag = "R2"; load(8'h3B);               // len 8 interleaved
    tag = "R6"; burst(8'h45, 0, 9);
    tag = "R6"; burst(8'hA2, 1, 9);
    tag = "R2"; load(8'h39);               // len 2 interleaved
    tag = "R7"; burst(8'h11, 0, 3);
    tag = "R2"; load(8'h21);               // len 2 seq, cl 2
    tag = "R7"; burst(8'hFF, 0, 3);
    tag = "R2"; load(8'h12);               // len 4 seq, cl 1
    tag = "R7"; burst(8'h02, 0, 5);

    tag = "R3"; load(8'h34);               // length code 100
    tag = "R3"; burst(8'h06, 0, 5);
    tag = "R3"; load(8'h3F);               // full page with interleave
    tag = "R3"; load(8'h02);               // latency code 000
    tag = "R3"; load(8'h42);               // latency code 100
    tag = "R3"; burst(8'h09, 0, 5);
    tag = "R2"; load(8'h23);               // legal word clears error

    tag = "R2"; load(8'h37);               // full page
    tag = "R8"; cyc(0, 8'h00, 1, 8'hFA, 0, 0);
    idle(300);
    tag = "R10"; cyc(0, 8'h00, 0, 8'h00, 0, 1);
    idle(2);

    tag = "R9"; load(8'hB3);               // len 8, single-beat write
    tag = "R9"; burst(8'h50, 1, 3);
    tag = "R9"; burst(8'h50, 0, 9);
    tag = "R9"; load(8'hB7);               // full page, single-beat write
    tag = "R9"; burst(8'h77, 1, 3);
    tag = "R9"; load(8'h33);

    tag = "R10"; cyc(0, 8'h00, 1, 8'h20, 0, 0);
    idle(2);
    cyc(0, 8'h00, 0, 8'h00, 0, 1);
    idle(2);

    tag = "R11"; cyc(0, 8'h00, 1, 8'h30, 0, 0);
    idle(2);
    cyc(0, 8'h00, 1, 8'h6E, 1, 0);
    cyc(0, 8'h00, 1, 8'h91, 0, 0);
    cyc(0, 8'h00, 1, 8'hC4, 0, 1);        // start beats terminate
    idle(10);

    tag = "R12"; cyc(0, 8'h00, 1, 8'h13, 0, 0);
    idle(1);
    load(8'h38);                           // becomes len 1 interleaved mid burst
    idle(8);
    tag = "R12"; burst(8'h13, 0, 2);
    tag = "R12"; cyc(1, 8'h3B, 1, 8'h2C, 0, 0);  // load with start: old mode used
    idle(3);
    tag = "R12"; burst(8'h2C, 0, 9);

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule